// File: doc/BRIEF.md
# Link Activity Measurement Counter

This block measures one chosen aspect of link activity over a window of time and keeps the result in a 64-bit accumulator. The metric is either the number of clock cycles the link spends in a given power or training state, or the number of payload units moved in one direction for one of two traffic classes. One payload unit is 16 bytes, and each payload strobe adds one unit. The window is either a fixed duration taken from a table of codes, or it is manual, in which case it runs until software clears the start bit.

Software writes a control word that holds a metric code, a duration code and a start bit. It then polls the start bit, which reads back as 1 while a measurement runs. The result is read as two 32-bit words. Both words show the live accumulator, and nothing latches them together. A reader that needs a coherent value must read the upper word, then the lower word, then the upper word again, and retry if the two upper values differ. The `CLK_FREQ_HZ` parameter turns each duration code into a cycle count.

Top module: `link_meas_counter`

## Requirements
- R1: After reset, the control word, both result words and the running flag all read as zero.
- R2: The control word is at address 0x10. Bits [31:24] hold the metric code, bits [15:8] hold the duration code, and bit 0 is start/running. The low result word is at 0x14 and the high result word is at 0x18. A read returns its data on `reg_rdata` in the cycle after the request and holds it until the next read. Any other address reads as zero.
- R3: Writing the control word with bit 0 set while idle clears the 64-bit result and starts counting. The first cycle counted is the one after the write.
- R4: Cycle metrics add one per counted cycle. Code 0x00 counts every cycle. Codes 0x01 to 0x08 count cycles in which `link_state[code-1]` is high. The bit order of `link_state` is: transmit L0s, receive L0s, L0, L1, L1.1, L1.2, configuration/recovery, L1 auxiliary. Code 0x09 counts cycles in which bits 0 and 1 are both high.
- R5: Payload metrics 0x20 to 0x23 add one 16-byte unit per cycle in which `payload_beat[code-0x20]` is high. Any other strobe bit has no effect. Metric codes outside 0x00 to 0x09 and 0x20 to 0x23 count nothing.
- R6: The timed duration codes are 0x01=1 ms, 0x02=10 ms, 0x03=100 ms, 0x04=1 s, 0x05=2 s, 0x06=4 s and 0xFF=4 us. Each becomes a limit of L cycles at `CLK_FREQ_HZ`. The measurement counts exactly L cycles, then stops by itself, and bit 0 reads back as 0.
- R7: Duration code 0x00 (and any code not listed in R6) is manual: counting goes on until the control word is written with bit 0 clear. That write stops any measurement, and the result then holds its value.
- R8: A control write made while a measurement runs stores the metric and duration fields, and they read back. It does not change the running measurement, which keeps its original metric and window until the next start.
- R9: The two result words show the live accumulator bits [31:0] and [63:32]. They are not captured together, so successive reads during a run return advancing values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| link_state | input | 8 | Per-state residency indications (R4 order) |
| payload_beat | input | 4 | Payload unit strobes: tx class A, rx class A, tx class B, rx class B |

## Verification
The hardest situation to reach from the ports is the timed self-stop, because real durations run to hundreds of millions of cycles. The bench builds the block with a 1 MHz clock setting, so the 4 us code becomes exactly four cycles and the 1 ms and 10 ms codes become 1000 and 10000 cycles. Every metric code can then be run to its natural end with constant input levels, and the result must equal the limit or zero. The second hard case is a control write during a run. The bench starts an L1 measurement with L1 held low, rewrites the fields to count every cycle over a four-cycle window, and then checks that the count stays at zero and the run is still active well past four cycles.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 64;
  localparam int STATE_W = 8;
  localparam int BEAT_W  = 4;
  localparam int CODE_W  = 8;

  localparam logic [7:0] ADDR_CTRL = 8'h10;
  localparam logic [7:0] ADDR_LO   = 8'h14;
  localparam logic [7:0] ADDR_HI   = 8'h18;

  localparam logic [CODE_W-1:0] MET_ALL     = 8'h00;
  localparam logic [CODE_W-1:0] MET_L0S_ANY = 8'h09;
  localparam logic [CODE_W-1:0] MET_PAY0    = 8'h20;

  localparam logic [CODE_W-1:0] DUR_MANUAL = 8'h00;
  localparam logic [CODE_W-1:0] DUR_1MS    = 8'h01;
  localparam logic [CODE_W-1:0] DUR_10MS   = 8'h02;
  localparam logic [CODE_W-1:0] DUR_100MS  = 8'h03;
  localparam logic [CODE_W-1:0] DUR_1S     = 8'h04;
  localparam logic [CODE_W-1:0] DUR_2S     = 8'h05;
  localparam logic [CODE_W-1:0] DUR_4S     = 8'h06;
  localparam logic [CODE_W-1:0] DUR_4US    = 8'hFF;

  typedef struct packed {
    logic [CODE_W-1:0] metric;
    logic [CODE_W-1:0] dur;
  } meas_cfg_t;
endpackage

// File: rtl/lmc_dur_decode.sv
module lmc_dur_decode
  import lmc_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int TMR_W = 29
) (
  input  logic [CODE_W-1:0] dur,
  output logic              timed,
  output logic [TMR_W-1:0]  limit
);
  // cycle counts per window, never below one cycle
  localparam longint unsigned RAW_4US = (CLK_FREQ_HZ * 4) / 1_000_000;
  localparam longint unsigned RAW_1MS = CLK_FREQ_HZ / 1000;
  localparam longint unsigned RAW_10M = CLK_FREQ_HZ / 100;
  localparam longint unsigned RAW_100 = CLK_FREQ_HZ / 10;
  localparam logic [TMR_W-1:0] LIM_4US = TMR_W'((RAW_4US == 0) ? 1 : RAW_4US);
  localparam logic [TMR_W-1:0] LIM_1MS = TMR_W'((RAW_1MS == 0) ? 1 : RAW_1MS);
  localparam logic [TMR_W-1:0] LIM_10M = TMR_W'((RAW_10M == 0) ? 1 : RAW_10M);
  localparam logic [TMR_W-1:0] LIM_100 = TMR_W'((RAW_100 == 0) ? 1 : RAW_100);
  localparam logic [TMR_W-1:0] LIM_1S  = TMR_W'(CLK_FREQ_HZ);
  localparam logic [TMR_W-1:0] LIM_2S  = TMR_W'(CLK_FREQ_HZ * 2);
  localparam logic [TMR_W-1:0] LIM_4S  = TMR_W'(CLK_FREQ_HZ * 4);

  always_comb begin
    timed = 1'b1;
    limit = '0;
    case (dur)
      DUR_4US:   limit = LIM_4US;
      DUR_1MS:   limit = LIM_1MS;
      DUR_10MS:  limit = LIM_10M;
      DUR_100MS: limit = LIM_100;
      DUR_1S:    limit = LIM_1S;
      DUR_2S:    limit = LIM_2S;
      DUR_4S:    limit = LIM_4S;
      default:   timed = 1'b0;
    endcase
  end
endmodule

// File: rtl/lmc_event_sel.sv
module lmc_event_sel
  import lmc_pkg::*;
(
  input  logic [CODE_W-1:0]  metric,
  input  logic [STATE_W-1:0] link_state,
  input  logic [BEAT_W-1:0]  payload_beat,
  output logic               hit
);
  always_comb begin
    hit = 1'b0;
    if (metric == MET_ALL) hit = 1'b1;
    for (int i = 0; i < STATE_W; i++)
      if (metric == CODE_W'(i + 1)) hit = link_state[i];
    if (metric == MET_L0S_ANY) hit = link_state[0] & link_state[1];
    for (int j = 0; j < BEAT_W; j++)
      if (metric == MET_PAY0 + CODE_W'(j)) hit = payload_beat[j];
  end
endmodule

// File: rtl/lmc_accum.sv
module lmc_accum #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + W'(1);
  end
endmodule

// File: rtl/link_meas_counter.sv
module link_meas_counter
  import lmc_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [STATE_W-1:0]  link_state,
  input  logic [BEAT_W-1:0]   payload_beat
);
  localparam int TMR_W = $clog2(4 * CLK_FREQ_HZ + 1);

  meas_cfg_t         cfg_sh;
  meas_cfg_t         cfg_act;
  logic              run_q;
  logic [TMR_W-1:0]  timer_q;
  logic [CNT_W-1:0]  result_q;
  logic              timed;
  logic [TMR_W-1:0]  limit;
  logic              hit;
  logic              wr_ctrl, start_req, stop_req, last_cyc;

  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign start_req = wr_ctrl && reg_wdata[0] && !run_q;
  assign stop_req  = wr_ctrl && !reg_wdata[0];
  assign last_cyc  = timed && (timer_q == limit - TMR_W'(1));

  lmc_dur_decode #(.CLK_FREQ_HZ(CLK_FREQ_HZ), .TMR_W(TMR_W)) dur_i (
    .dur(cfg_act.dur), .timed(timed), .limit(limit)
  );

  lmc_event_sel sel_i (
    .metric(cfg_act.metric), .link_state(link_state),
    .payload_beat(payload_beat), .hit(hit)
  );

  lmc_accum #(.W(CNT_W)) acc_i (
    .clk(clk), .rst(rst), .clr(start_req),
    .inc(run_q && hit && !stop_req), .q(result_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_sh  <= '0;
      cfg_act <= '0;
      run_q   <= 1'b0;
      timer_q <= '0;
    end else begin
      if (wr_ctrl) cfg_sh <= '{metric: reg_wdata[31:24], dur: reg_wdata[15:8]};
      if (start_req) begin
        cfg_act <= '{metric: reg_wdata[31:24], dur: reg_wdata[15:8]};
        run_q   <= 1'b1;
        timer_q <= '0;
      end else if (stop_req) begin
        run_q <= 1'b0;
      end else if (run_q && timed) begin
        timer_q <= timer_q + TMR_W'(1);
        if (last_cyc) run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(ADDR_CTRL): reg_rdata <= {cfg_sh.metric, 8'h00, cfg_sh.dur, 7'h00, run_q};
        ADDR_W'(ADDR_LO):   reg_rdata <= result_q[WORD_W-1:0];
        ADDR_W'(ADDR_HI):   reg_rdata <= result_q[CNT_W-1:WORD_W];
        default:            reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/link_meas_counter_chk.sv
module link_meas_counter_chk #(
  parameter int TMR_W = 29,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             run_q,
  input logic             timed,
  input logic [TMR_W-1:0] limit,
  input logic [TMR_W-1:0] timer_q,
  input logic [CNT_W-1:0] result_q,
  input logic [15:0]      act_cfg
);
  // R3
  clr_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> result_q == '0);
  // R7
  idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (run_q || $stable(result_q)));
  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |=> (result_q - $past(result_q)) <= CNT_W'(1));
  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && timed) |-> timer_q < limit);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> $stable(act_cfg));
endmodule

bind link_meas_counter link_meas_counter_chk #(.TMR_W(TMR_W), .CNT_W(lmc_pkg::CNT_W)) chk_i (
  .clk(clk), .rst(rst), .run_q(run_q), .timed(timed), .limit(limit),
  .timer_q(timer_q), .result_q(result_q), .act_cfg(cfg_act)
);

// File: tb/link_meas_counter_tb_top.sv
`timescale 1ns/1ps
module link_meas_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  link_state = '0;
  logic [3:0]  payload_beat = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  link_meas_counter #(.CLK_FREQ_HZ(1_000_000), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_state(link_state),
    .payload_beat(payload_beat)
  );

  typedef struct packed {
    logic [7:0]  metric;
    logic [7:0]  dur;
    logic [7:0]  st;
    logic [3:0]  bt;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'hFF, 8'h00, 4'h0, 32'd4},     // R4 every cycle, R6 4us
    '{8'h01, 8'hFF, 8'h01, 4'h0, 32'd4},     // R4 tx L0s
    '{8'h01, 8'hFF, 8'hFE, 4'h0, 32'd0},     // R4 other states ignored
    '{8'h03, 8'hFF, 8'h04, 4'h0, 32'd4},     // R4 L0
    '{8'h08, 8'hFF, 8'h80, 4'h0, 32'd4},     // R4 L1 aux
    '{8'h09, 8'hFF, 8'h01, 4'h0, 32'd0},     // R4 combined needs both
    '{8'h09, 8'hFF, 8'h03, 4'h0, 32'd4},     // R4 combined
    '{8'h07, 8'hFF, 8'h40, 4'h0, 32'd4},     // R4 cfg/recovery
    '{8'h20, 8'hFF, 8'h00, 4'h1, 32'd4},     // R5 tx class A
    '{8'h23, 8'hFF, 8'hFF, 4'h7, 32'd0},     // R5 other strobes ignored
    '{8'h23, 8'hFF, 8'h00, 4'h8, 32'd4},     // R5 rx class B
    '{8'h0A, 8'hFF, 8'hFF, 4'hF, 32'd0},     // R5 unused code counts nothing
    '{8'h00, 8'h01, 8'h00, 4'h0, 32'd1000},  // R6 1 ms
    '{8'h06, 8'h02, 8'h20, 4'h0, 32'd10000}  // R6 10 ms
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      reg_read(8'h10, v);
      if (!v[0]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, a, b;
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    reg_read(8'h10, v); check("R1 ctrl", v, 32'h0);
    reg_read(8'h14, v); check("R1 low", v, 32'h0);
    reg_read(8'h18, v); check("R1 high", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      link_state = VECS[i].st;
      payload_beat = VECS[i].bt;
      reg_write(8'h10, {VECS[i].metric, 8'h00, VECS[i].dur, 8'h01});
      wait_idle(ok);
      check("R6 self-stop", {31'h0, ok}, 32'h1);
      reg_read(8'h14, v); check($sformatf("R4/R5/R6 vector %0d", i), v, VECS[i].exp);
      reg_read(8'h18, v); check("R9 high word", v, 32'h0);
      reg_read(8'h10, v); check("R2 ctrl readback", v, {VECS[i].metric, 8'h00, VECS[i].dur, 8'h00});
    end
    link_state = '0; payload_beat = '0;

    // R3 R7 manual window counts exactly the cycles between start and stop
    reg_write(8'h10, 32'h0000_0001);
    repeat (7) @(negedge clk);
    reg_write(8'h10, 32'h0000_0000);
    reg_read(8'h14, v); check("R3 manual count", v, 32'd7);
    repeat (5) @(negedge clk);
    reg_read(8'h14, v); check("R7 frozen after stop", v, 32'd7);
    reg_read(8'h10, v); check("R7 start cleared", v, 32'h0);

    // R9 live unlatched view
    reg_write(8'h10, 32'h0000_0001);
    repeat (3) @(negedge clk);
    reg_read(8'h14, a);
    reg_read(8'h14, b);
    check("R9 live advance", b, a + 32'd1);
    reg_write(8'h10, 32'h0000_0000);

    // R5 payload strobes, one unit per strobe, neighbour strobe ignored
    reg_write(8'h10, 32'h2100_0001);
    for (int i = 0; i < 10; i++) begin
      payload_beat = {2'b00, (10'b10_1100_1010 >> i) & 10'h1 ? 1'b1 : 1'b0, 1'b1};
      @(negedge clk);
    end
    payload_beat = '0;
    reg_write(8'h10, 32'h0000_0000);
    reg_read(8'h14, v); check("R5 strobe count", v, 32'd5);

    // R8 write during a run does not alter the running measurement
    reg_write(8'h10, 32'h0400_0001);          // L1, manual, L1 held low
    repeat (3) @(negedge clk);
    reg_write(8'h10, 32'h0000_FF01);          // every cycle, 4 us
    reg_read(8'h10, v); check("R8 fields stored", v, 32'h0000_FF01);
    repeat (10) @(negedge clk);
    reg_read(8'h10, v); check("R8 still running", v, 32'h0000_FF01);
    reg_read(8'h14, v); check("R8 old metric kept", v, 32'd0);
    reg_write(8'h10, 32'h0000_FF00);
    reg_write(8'h10, 32'h0000_FF01);          // next start uses new fields
    wait_idle(ok);
    reg_read(8'h14, v); check("R8 new fields on next start", v, 32'd4);

    // R2 unmapped address and read hold
    reg_read(8'h1C, v); check("R2 unmapped", v, 32'h0);
    reg_read(8'h14, v);
    repeat (3) @(negedge clk);
    check("R2 read data held", reg_rdata, 32'd4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule